// File: doc/BRIEF.md
# Serial Transmit Channel with Watermark Interrupt

This block is the sending side of a small serial port that a processor drives through 32-bit register accesses. Software writes bytes into an eight-entry queue. A shift stage removes them one at a time and sends each as an asynchronous frame: a low start bit, eight data bits with the least significant bit first, and one or two high stop bits. A programmable divisor sets the bit rate.

A level interrupt tells software when the queue has drained below a level it has chosen, so that it can refill the queue in bursts. Reading the data register returns only whether the queue is full. A polling driver therefore needs no separate status register.

Top module: `uart_tx_chan`

## Requirements
- R1: After reset the serial line is high, the interrupt is low, the divisor reads 3, and the control, enable and data registers read 0.
- R2: Register byte offsets are 0x00 data, 0x08 control, 0x10 interrupt enable, 0x14 interrupt pending and 0x18 divisor. Control bit 0 is transmit enable, bit 1 selects two stop bits, and bits 18:16 are the watermark. Enable bit 0 is the watermark interrupt enable. The divisor is 16 bits wide. Unimplemented bits read 0.
- R3: A write to the data register enqueues bits 7:0 into an eight-entry queue. A read of the data register returns 1 in bit 31 when the queue holds eight entries, and 0 in every other bit.
- R4: A data write while the queue is full is dropped, and the queued bytes are not disturbed.
- R5: The line idles high. A frame is a low start bit, then bits 0 to 7 of the byte, then high stop bits. Bytes leave in the order they were written.
- R6: Every bit lasts divisor+1 clock cycles.
- R7: With control bit 1 clear there is one stop bit, and with it set there are two. The start edges of back-to-back frames lie (9+stop bits)×(divisor+1)+1 cycles apart.
- R8: With transmit enable clear, no new frame starts and queued bytes stay queued. A frame already under way completes normally.
- R9: Pending bit 0 reads 1 exactly when queue occupancy is strictly less than the watermark. With a watermark of 0 it never sets. The pending register ignores writes.
- R10: The interrupt output is pending bit 0 ANDed with enable bit 0.
- R11: A byte that has moved into the shift stage no longer counts toward occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational during a read strobe |
| txd_o | output | 1 | Serial output |
| irq_o | output | 1 | Watermark interrupt, level |

## Verification
The bench uses the default build: an eight-entry queue, a 16-bit divisor and 8-bit data. With a queue that short, every pairing of occupancy 0 to 8 with every watermark value 0 to 7 can be applied, and each pairing is checked against the pending bit and the interrupt. The frame checks cover divisors 0, 1, 3 and 6 with both stop-bit settings, so the measured start-bit width and the spacing between frames can be compared with the arithmetic in R6 and R7. The queue can be filled in a few writes, so the dropped ninth byte and a disable in the middle of a frame are also exercised.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_DATA = 5'h00;
  localparam logic [REG_AW-1:0] OFS_CTRL = 5'h08;
  localparam logic [REG_AW-1:0] OFS_IE   = 5'h10;
  localparam logic [REG_AW-1:0] OFS_IP   = 5'h14;
  localparam logic [REG_AW-1:0] OFS_DIV  = 5'h18;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_STOP_BIT = 1;
  localparam int CTRL_WM_LSB   = 16;
  localparam int WM_W          = 3;
  localparam int FULL_BIT      = 31;

  typedef struct packed {
    logic [WM_W-1:0] wm;
    logic            two_stop;
    logic            en;
  } tx_ctrl_t;
endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  p_drop_when_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (count_o == CNT_W'(DEPTH) && $stable(rd_ptr_q)));
endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // Counter reloads at frame start so each bit spans exactly div+1 cycles.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i)      cnt_q <= div_i;
    else if (run_i) begin
      if (cnt_q == '0)       cnt_q <= div_i;
      else                   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = run_i & ~restart_i & (cnt_q == '0);

  p_tick_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i) |=> (cnt_q == $past(div_i)));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DW = 8,
  localparam int FRAME_W = DW + 3,
  localparam int BCNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          avail_i,
  input  logic [DW-1:0] data_i,
  input  logic          two_stop_i,
  input  logic          tick_i,
  output logic          pop_o,
  output logic          busy_o,
  output logic          txd_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [BCNT_W-1:0]  left_q;
  logic               busy_q;

  assign pop_o  = ~busy_q & en_i & avail_i;
  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (pop_o) begin
      sh_q   <= {2'b11, data_i, 1'b0};
      left_q <= two_stop_i ? BCNT_W'(DW + 3) : BCNT_W'(DW + 2);
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (left_q == BCNT_W'(1)) begin
        busy_q <= 1'b0;
      end else begin
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
      end
    end
  end

  p_idle_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> txd_o);

  p_start_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !txd_o);

  p_hold_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !en_i) |=> !busy_q);
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 16,
  parameter int DIV_RST    = 3,
  parameter int DATA_W     = 8,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              txd_o,
  output logic              irq_o
);
  tx_ctrl_t         ctrl_q;
  logic             ie_q;
  logic [DIV_W-1:0] div_q;

  logic wr_en, rd_en, wr_data, wr_ctrl, wr_ie, wr_div, wr_ip;
  assign wr_en   = req_i & we_i;
  assign rd_en   = req_i & ~we_i;
  assign wr_data = wr_en && (addr_i == OFS_DATA);
  assign wr_ctrl = wr_en && (addr_i == OFS_CTRL);
  assign wr_ie   = wr_en && (addr_i == OFS_IE);
  assign wr_div  = wr_en && (addr_i == OFS_DIV);
  assign wr_ip   = wr_en && (addr_i == OFS_IP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ie_q   <= 1'b0;
      div_q  <= DIV_W'(DIV_RST);
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en       <= wdata_i[CTRL_EN_BIT];
        ctrl_q.two_stop <= wdata_i[CTRL_STOP_BIT];
        ctrl_q.wm       <= wdata_i[CTRL_WM_LSB +: WM_W];
      end
      if (wr_ie)  ie_q  <= wdata_i[0];
      if (wr_div) div_q <= wdata_i[DIV_W-1:0];
    end
  end

  logic [DATA_W-1:0] head;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_full, fifo_empty, pop, busy, tick;

  uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .DW(DATA_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_data),
    .data_i  (wdata_i[DATA_W-1:0]),
    .pop_i   (pop),
    .data_o  (head),
    .count_o (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (pop),
    .run_i     (busy),
    .div_i     (div_q),
    .tick_o    (tick)
  );

  uart_tx_shift #(.DW(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl_q.en),
    .avail_i    (~fifo_empty),
    .data_i     (head),
    .two_stop_i (ctrl_q.two_stop),
    .tick_i     (tick),
    .pop_o      (pop),
    .busy_o     (busy),
    .txd_o      (txd_o)
  );

  logic pend;
  assign pend  = int'(fifo_cnt) < int'(ctrl_q.wm);
  assign irq_o = pend & ie_q;

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      case (addr_i)
        OFS_DATA: rdata_o[FULL_BIT] = fifo_full;
        OFS_CTRL: begin
          rdata_o[CTRL_EN_BIT]              = ctrl_q.en;
          rdata_o[CTRL_STOP_BIT]            = ctrl_q.two_stop;
          rdata_o[CTRL_WM_LSB +: WM_W]      = ctrl_q.wm;
        end
        OFS_IE:   rdata_o[0] = ie_q;
        OFS_IP:   rdata_o[0] = pend;
        OFS_DIV:  rdata_o[DIV_W-1:0] = div_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i};

  p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_q || int'(u_fifo.count_o) >= int'(ctrl_q.wm)) |-> !irq_o);

  p_ip_readonly_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ip |=> ($stable(ctrl_q) && $stable(ie_q) && $stable(div_q)));
endmodule

// File: tb/uart_tx_chan_test.sv
module uart_tx_chan_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        txd, irq;

  always #5 clk = ~clk;

  uart_tx_chan uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .txd_o(txd), .irq_o(irq)
  );

  int cyc = 0;
  always @(posedge clk) cyc++;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_start(output int stamp, output bit ok);
    ok = 0; stamp = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (txd === 1'b0) begin stamp = cyc; ok = 1; return; end
    end
  endtask

  // Called at the centre of the start bit.
  task automatic recv_from_center(input int p, input string r, output logic [7:0] b);
    chk({r, " start low"}, {31'd0, txd}, 32'd0);
    for (int k = 0; k < 8; k++) begin negs(p); b[k] = txd; end
    negs(p);
    chk({r, " stop high"}, {31'd0, txd}, 32'd1);
  endtask

  task automatic recv_meas(input int p, output logic [7:0] b);
    int len = 1;
    while (txd === 1'b0 && len < 70000) begin
      @(negedge clk);
      if (txd === 1'b0) len++;
    end
    chk("R6 start bit width", len, p);
    negs(p / 2); b[0] = txd;
    for (int k = 1; k < 8; k++) begin negs(p); b[k] = txd; end
    negs(p);
    chk("R5 stop high", {31'd0, txd}, 32'd1);
  endtask

  localparam logic [4:0] A_DATA = 5'h00, A_CTRL = 5'h08, A_IE = 5'h10,
                         A_IP = 5'h14, A_DIV = 5'h18;

  initial begin : watchdog
    #(150000 * 10);
    n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [7:0]  b;
    int s1, s2;
    bit ok;

    negs(3);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 txd idle", {31'd0, txd}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(A_DIV, d);  chk("R1 div", d, 32'd3);
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'd0);
    rd(A_IE, d);   chk("R1 ie", d, 32'd0);
    rd(A_DATA, d); chk("R1 data", d, 32'd0);

    // R2 register map
    wr(A_CTRL, 32'h0005_0002); rd(A_CTRL, d); chk("R2 ctrl", d, 32'h0005_0002);
    wr(A_CTRL, 32'hFFFF_FFFC); rd(A_CTRL, d); chk("R2 ctrl mask", d, 32'h0007_0000);
    wr(A_DIV, 32'hABCD_1234);  rd(A_DIV, d);  chk("R2 div width", d, 32'h0000_1234);
    wr(A_IE, 32'hFFFF_FFFE);   rd(A_IE, d);   chk("R2 ie bit0", d, 32'd0);
    wr(A_IE, 32'd1);           rd(A_IE, d);   chk("R2 ie set", d, 32'd1);
    wr(A_IE, 32'd0);
    wr(A_DIV, 32'd3);
    wr(A_CTRL, 32'd0);

    // R9 pending ignores writes
    wr(A_CTRL, 32'h0003_0000); rd(A_IP, d); chk("R9 ip set", d, 32'd1);
    wr(A_IP, 32'd0);           rd(A_IP, d); chk("R9 ip write ignored", d, 32'd1);
    wr(A_CTRL, 32'd0);         rd(A_IP, d); chk("R9 wm0", d, 32'd0);
    wr(A_IP, 32'd1);           rd(A_IP, d); chk("R9 ip write ignored 2", d, 32'd0);

    // R9 R10 R3: sweep occupancy 0..8 against every watermark, tx disabled
    for (int c = 0; c <= 8; c++) begin
      for (int wm = 0; wm < 8; wm++) begin
        wr(A_CTRL, 32'(wm) << 16);
        rd(A_IP, d); chk("R9 pending", d, {31'd0, c < wm});
        wr(A_IE, 32'd1); chk("R10 irq enabled", {31'd0, irq}, {31'd0, c < wm});
        wr(A_IE, 32'd0); chk("R10 irq masked", {31'd0, irq}, 32'd0);
      end
      if (c < 8) begin
        wr(A_DATA, 32'hFFFF_FF00 | 32'(8'h30 + c));
        rd(A_DATA, d); chk("R3 full flag", d, (c == 7) ? 32'h8000_0000 : 32'd0);
      end
    end

    // R4 overflow write dropped
    wr(A_DATA, 32'h0000_00EE);
    rd(A_DATA, d); chk("R4 still full", d, 32'h8000_0000);
    wr(A_CTRL, 32'h0000_0001);  // div 3, one stop
    s1 = 0;
    for (int i = 0; i < 8; i++) begin
      wait_start(s2, ok);
      chk("R5 frame present", {31'd0, ok}, 32'd1);
      if (i > 0) chk("R7 gap one stop", s2 - s1, 10 * 4 + 1);
      s1 = s2;
      negs(2);
      recv_from_center(4, "R5", b);
      chk("R5 R3 byte order", {24'd0, b}, 32'(8'h30 + i));
    end
    ok = 1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (txd !== 1'b1) ok = 0; end
    chk("R4 ninth byte absent", {31'd0, ok}, 32'd1);

    // R11 shifted byte not counted
    wr(A_CTRL, 32'h0001_0001);
    wr(A_DATA, 32'h7E);
    wait_start(s1, ok);
    chk("R11 frame started", {31'd0, ok}, 32'd1);
    rd(A_IP, d); chk("R11 occupancy zero while sending", d, 32'd1);
    negs(60);

    // R8 disable mid-frame
    wr(A_CTRL, 32'd0);
    wr(A_DATA, 32'h3C);
    wr(A_DATA, 32'hC3);
    wr(A_CTRL, 32'd1);
    wait_start(s1, ok);
    chk("R8 first frame", {31'd0, ok}, 32'd1);
    wr(A_CTRL, 32'd0);  // two negedges: now at start-bit centre for p=4
    recv_from_center(4, "R8", b);
    chk("R8 frame completes", {24'd0, b}, 32'h3C);
    ok = 1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (txd !== 1'b1) ok = 0; end
    chk("R8 no new frame", {31'd0, ok}, 32'd1);
    wr(A_CTRL, 32'h0002_0000); rd(A_IP, d); chk("R8 byte kept (wm2)", d, 32'd1);
    wr(A_CTRL, 32'h0001_0000); rd(A_IP, d); chk("R8 byte kept (wm1)", d, 32'd0);
    wr(A_CTRL, 32'd1);
    wait_start(s1, ok);
    chk("R8 resumes", {31'd0, ok}, 32'd1);
    negs(2);
    recv_from_center(4, "R8", b);
    chk("R8 queued byte", {24'd0, b}, 32'hC3);
    negs(20);

    // R5 R6 R7 sweep over divisor and stop count
    for (int di = 0; di < 4; di++) begin
      for (int ns = 0; ns < 2; ns++) begin
        int dv, p;
        logic [7:0] b1, b2;
        dv = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 3 : 6;
        p  = dv + 1;
        b1 = (8'h5A ^ 8'(di * 37 + ns * 11)) | 8'h01;
        b2 = ~b1;
        wr(A_CTRL, 32'd0);
        wr(A_DIV, 32'(dv));
        wr(A_DATA, 32'(b1));
        wr(A_DATA, 32'(b2));
        wr(A_CTRL, 32'd1 | (32'(ns) << 1));
        wait_start(s1, ok);
        chk("R5 sweep frame1", {31'd0, ok}, 32'd1);
        recv_meas(p, b);
        chk("R5 sweep byte1", {24'd0, b}, {24'd0, b1});
        wait_start(s2, ok);
        chk("R5 sweep frame2", {31'd0, ok}, 32'd1);
        chk("R7 R6 frame spacing", s2 - s1, (9 + 1 + ns) * p + 1);
        negs(p / 2);
        recv_from_center(p, "R5 sweep", b);
        chk("R5 sweep byte2", {24'd0, b}, {24'd0, b2});
        negs(2 * p + 4);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule